// File: doc/BRIEF.md
# ADC Channel Sequencer Register Block

This block sits between a register bus and an external analog-to-digital converter. Software chooses any subset of up to sixteen channels by writing a selection word. The block then runs through the chosen channels in a loop. For each one it sends a one-cycle start request with a channel number to the converter. When the converter reports completion, the block stores the sample in that channel's result register and raises the channel's completion flag.

The bus side is a simple single-cycle register port with two byte lanes. Read data is combinational while the read strobe is high, and any side effect of an access takes place at the clock edge that ends it. The byte lanes set the rules. A write that includes the upper lane of the selection word aborts the running sequence and restarts it. A write to the lower lane alone only edits the low selection bits. A low-byte read of a result captures that result's upper byte, so that a following high-byte read gets a consistent pair.

Top module: `adc_seq_regs`

## Requirements
- R1: After reset, the selection word, all completion flags and all result registers read zero, and `cnv_start` stays low until a sequence is started.
- R2: While running, the block issues `cnv_start` as a one-cycle pulse with `cnv_ch` naming the next selected channel in ascending order, wrapping to the lowest selected channel after the highest. It has only one conversion outstanding and issues no new start until the previous one has reported `cnv_done`.
- R3: A completed conversion stores its sample left-adjusted in its result register (sample in bits 15:6, bits 5:0 zero) and sets that channel's flag on the same clock edge. Channel x's result is at word address 2+x. Flags are at word address 1, with bit x for channel x.
- R4: A write to the selection word (word address 0) with the upper lane enabled (`bus_be[1]`, bits 15:8) clears all flags and restarts from the lowest selected channel. A conversion in flight at that moment is discarded and writes no result.
- R5: A write of zero to the selection word with the upper lane enabled stops conversion, and no further `cnv_start` is issued.
- R6: A write with only the lower lane enabled (`bus_be` = 01) updates selection bits 7:0 and clears all flags. It does not restart the sequence, which continues from where it was.
- R7: Reads of the flag word return the live flags for the enabled lanes, with no capture and no side effect.
- R8: A read of a result register with both lanes enabled (`bus_be` = 11) clears that channel's flag.
- R9: A low-lane-only read (`bus_be` = 01) of result x captures the upper byte of result x and leaves the flag set. The next upper-lane-only read (`bus_be` = 10) of result x returns the captured byte. Any result read with the upper lane enabled clears the capture and that channel's flag.
- R10: If a completion and a flag-clearing access hit the same channel in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address: 0 selection, 1 flags, 2+x result of channel x |
| bus_be | input | 2 | Lane enables: bit 1 for bits 15:8, bit 0 for bits 7:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for enabled lanes, zero elsewhere |
| cnv_start | output | 1 | One-cycle conversion request |
| cnv_ch | output | CH_W | Channel of the current request |
| cnv_done | input | 1 | Converter completion pulse |
| cnv_data | input | RES_W | Converter sample, valid with `cnv_done` |

## Verification
The sequence is first driven with a sparse selection of channels 0, 2, 5 and 15. This shows whether ascending order, skipping of unselected channels and the wrap from channel 15 to channel 0 are all correct. A new selection written while a conversion is in flight separates an abort that discards the pending sample from one that wrongly stores it. A lower-lane-only write, when the next channel issued is compared with the model, separates continuing the sequence from restarting it. Repeated full-width reads of a single busy channel force a completion onto the same edge as a clear, which shows which of the two wins. Byte-lane reads taken around a fresh conversion separate the captured upper byte from the live one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int BUS_W  = 16;
   localparam int LANE_W = 8;
   localparam int RES_BASE = 2;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_DRAIN = 2'd3
   } seq_state_e;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CH_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] sel,
   input  logic              restart,
   input  logic              cnv_done,
   output logic              cnv_start,
   output logic [CH_W-1:0]   cnv_ch,
   output logic              cmp_vld,
   output logic [CH_W-1:0]   cmp_ch
);
   seq_state_e      state;
   logic [CH_W-1:0] cur_ch;
   logic [CH_W-1:0] from_ch;
   logic            start_q;

   // rotating search: first selected channel at or above f, wrapping
   function automatic logic [CH_W-1:0] pick(input logic [NUM_CH-1:0] s,
                                            input logic [CH_W-1:0] f);
      logic [CH_W-1:0] r;
      logic            found;
      int              idx;
      r = '0;
      found = 1'b0;
      for (int k = 0; k < NUM_CH; k++) begin
         idx = (int'(f) + k) % NUM_CH;
         if (!found && s[idx]) begin
            r = CH_W'(idx);
            found = 1'b1;
         end
      end
      return r;
   endfunction

   function automatic logic [CH_W-1:0] succ(input logic [CH_W-1:0] c);
      return (int'(c) == NUM_CH - 1) ? '0 : c + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         cur_ch  <= '0;
         from_ch <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (restart) begin
                  state   <= SQ_ISSUE;
                  from_ch <= '0;
               end
            end
            SQ_ISSUE: begin
               if (restart) begin
                  from_ch <= '0;
               end else if (sel == '0) begin
                  state <= SQ_IDLE;
               end else begin
                  cur_ch  <= pick(sel, from_ch);
                  start_q <= 1'b1;
                  state   <= SQ_WAIT;
               end
            end
            SQ_WAIT: begin
               if (restart) begin
                  from_ch <= '0;
                  state   <= cnv_done ? SQ_ISSUE : SQ_DRAIN;
               end else if (cnv_done) begin
                  from_ch <= succ(cur_ch);
                  state   <= SQ_ISSUE;
               end
            end
            default: begin
               if (restart) from_ch <= '0;
               if (cnv_done) state <= SQ_ISSUE;
            end
         endcase
      end
   end

   assign cnv_start = start_q;
   assign cnv_ch    = cur_ch;
   assign cmp_vld   = (state == SQ_WAIT) && cnv_done && !restart;
   assign cmp_ch    = cur_ch;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |=> !cnv_start); // R2

   AST_START_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> ((($past(sel)) >> cnv_ch) & NUM_CH'(1)) != '0); // R2
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store #(
   parameter int NUM_CH = 16,
   parameter int CH_W   = 4,
   parameter int RES_W  = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmp_vld,
   input  logic [CH_W-1:0]              cmp_ch,
   input  logic [RES_W-1:0]             cmp_data,
   input  logic                         clr_all,
   input  logic [NUM_CH-1:0]            rd_clr,
   output logic [NUM_CH-1:0]            flags,
   output logic [NUM_CH-1:0][RES_W-1:0] res
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = cmp_vld && (cmp_ch == CH_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags[i] <= 1'b0;
            res[i]   <= '0;
         end else begin
            if (hit) begin
               flags[i] <= 1'b1;
               res[i]   <= cmp_data;
            end else if (clr_all || rd_clr[i]) begin
               flags[i] <= 1'b0;
            end
         end
      end

      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_clr[i] && !hit) |=> !flags[i]); // R8
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_vld |=> flags[$past(cmp_ch)]); // R10
endmodule

// File: rtl/adc_seq_bus.sv
module adc_seq_bus
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CH_W   = 4,
   parameter int RES_W  = 10,
   parameter int ADDR_W = 5
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_wr,
   input  logic                         bus_rd,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [1:0]                   bus_be,
   input  logic [BUS_W-1:0]             bus_wdata,
   output logic [BUS_W-1:0]             bus_rdata,
   input  logic [NUM_CH-1:0]            flags,
   input  logic [NUM_CH-1:0][RES_W-1:0] res,
   output logic [NUM_CH-1:0]            sel,
   output logic                         restart,
   output logic                         clr_all,
   output logic [NUM_CH-1:0]            rd_clr
);
   localparam logic [BUS_W-1:0] SEL_MASK = BUS_W'((33'd1 << NUM_CH) - 33'd1);
   localparam int               PAD      = BUS_W - RES_W;

   logic [BUS_W-1:0]  sel_q;
   logic              sel_hit, sts_hit, res_hit;
   logic [CH_W-1:0]   res_idx;
   logic [BUS_W-1:0]  live_word;
   logic [LANE_W-1:0] lat_byte;
   logic [CH_W-1:0]   lat_ch;
   logic              lat_vld;
   logic [BUS_W-1:0]  word;

   assign sel_hit = (bus_addr == '0);
   assign sts_hit = (bus_addr == ADDR_W'(1));
   assign res_hit = (bus_addr >= ADDR_W'(RES_BASE)) &&
                    (bus_addr <  ADDR_W'(RES_BASE + NUM_CH));
   assign res_idx = CH_W'(bus_addr - ADDR_W'(RES_BASE));

   assign restart = bus_wr && sel_hit && bus_be[1];
   assign clr_all = bus_wr && sel_hit && (bus_be != 2'b00);
   assign sel     = sel_q[NUM_CH-1:0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
      assign rd_clr[i] = bus_rd && res_hit && bus_be[1] && (res_idx == CH_W'(i));
   end

   assign live_word = BUS_W'(res[res_idx]) << PAD;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= '0;
         lat_byte <= '0;
         lat_ch   <= '0;
         lat_vld  <= 1'b0;
      end else begin
         if (bus_wr && sel_hit) begin
            sel_q <= {bus_be[1] ? bus_wdata[BUS_W-1:LANE_W] : sel_q[BUS_W-1:LANE_W],
                      bus_be[0] ? bus_wdata[LANE_W-1:0]     : sel_q[LANE_W-1:0]} & SEL_MASK;
         end
         if (bus_rd && res_hit) begin
            if (bus_be == 2'b01) begin
               lat_byte <= live_word[BUS_W-1:LANE_W];
               lat_ch   <= res_idx;
               lat_vld  <= 1'b1;
            end else if (bus_be[1]) begin
               lat_vld <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      word = '0;
      if (sel_hit) begin
         word = sel_q;
      end else if (sts_hit) begin
         word = BUS_W'(flags);
      end else if (res_hit) begin
         word = live_word;
         if (bus_be == 2'b10 && lat_vld && lat_ch == res_idx)
            word[BUS_W-1:LANE_W] = lat_byte;
      end
      bus_rdata = bus_rd ? (word & {{LANE_W{bus_be[1]}}, {LANE_W{bus_be[0]}}}) : '0;
   end

   AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_hit && bus_be == 2'b01) |=>
         sel_q[BUS_W-1:LANE_W] == $past(sel_q[BUS_W-1:LANE_W])); // R6
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int RES_W  = 10,
   parameter int ADDR_W = 5,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_be,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   output logic              cnv_start,
   output logic [CH_W-1:0]   cnv_ch,
   input  logic              cnv_done,
   input  logic [RES_W-1:0]  cnv_data
);
   if (NUM_CH < 2 || NUM_CH > BUS_W) begin : g_bad_ch
      $error("NUM_CH must lie between 2 and the bus width");
   end
   if (RES_W < LANE_W || RES_W > BUS_W) begin : g_bad_res
      $error("RES_W must lie between one lane and the bus width");
   end
   if ((1 << ADDR_W) < RES_BASE + NUM_CH) begin : g_bad_addr
      $error("ADDR_W too small for the result registers");
   end

   logic [NUM_CH-1:0]            sel;
   logic                         restart;
   logic                         clr_all;
   logic [NUM_CH-1:0]            rd_clr;
   logic [NUM_CH-1:0]            flags;
   logic [NUM_CH-1:0][RES_W-1:0] res;
   logic                         cmp_vld;
   logic [CH_W-1:0]              cmp_ch;

   adc_seq_bus #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W), .ADDR_W(ADDR_W)) u_bus (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_be, .bus_wdata, .bus_rdata,
      .flags, .res, .sel, .restart, .clr_all, .rd_clr
   );

   adc_seq_fsm #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_fsm (
      .clk, .rst_n, .sel, .restart, .cnv_done, .cnv_start, .cnv_ch, .cmp_vld, .cmp_ch
   );

   adc_seq_store #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) u_store (
      .clk, .rst_n, .cmp_vld, .cmp_ch, .cmp_data(cnv_data), .clr_all, .rd_clr, .flags, .res
   );

   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == '0 && bus_be[1]) |=> (flags == '0)); // R4
endmodule

// File: tb/tb_adc_seq_regs.sv
module tb_adc_seq_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 16;
   localparam int LAT = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        cnv_start;
   logic [3:0]  cnv_ch;
   logic        cnv_done = 1'b0;
   logic [9:0]  cnv_data = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_regs dut (
      .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_be, .bus_wdata, .bus_rdata,
      .cnv_start, .cnv_ch, .cnv_done, .cnv_data
   );

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   logic [15:0] sel_m, flags_m;
   logic [9:0]  res_m [NCH];
   logic [7:0]  latch_m;
   int          from_m, mch, exp_ch_q, lch, nstart;
   bit          inflight, discard, active, lv;

   function automatic int pick_m(input logic [15:0] s, input int f);
      for (int k = 0; k < NCH; k++)
         if (s[(f + k) % NCH]) return (f + k) % NCH;
      return 0;
   endfunction

   function automatic logic [15:0] exp_rd(input int a, input logic [1:0] be);
      logic [15:0] w;
      w = '0;
      if (a == 0) w = sel_m;
      else if (a == 1) w = flags_m;
      else if (a >= 2 && a < 2 + NCH) begin
         w = {res_m[a-2], 6'b0};
         if (be == 2'b10 && lv && lch == a - 2) w[15:8] = latch_m;
      end
      return w & {{8{be[1]}}, {8{be[0]}}};
   endfunction

   always @(posedge clk) begin
      int tmp, a;
      logic [15:0] nsel;
      bit used;
      if (!rst_n) begin
         sel_m = '0; flags_m = '0; latch_m = '0;
         for (int i = 0; i < NCH; i++) res_m[i] = '0;
         from_m = 0; mch = 0; exp_ch_q = 0; lch = 0; nstart = 0;
         inflight = 0; discard = 0; active = 0; lv = 0;
      end else begin
         tmp = pick_m(sel_m, from_m);
         a = int'(bus_addr);
         used = 0;
         if (cnv_start) begin
            chk(active, "R5 start only while running", 32'(cnv_start), 32'(0));
            chk(!inflight, "R2 single outstanding conversion", 32'(inflight), 32'(0));
            chk(int'(cnv_ch) == exp_ch_q, "R2 channel order", 32'(cnv_ch), 32'(exp_ch_q));
            inflight = 1; mch = int'(cnv_ch); nstart++;
         end
         if (bus_rd && a >= 2 && a < 2 + NCH) begin
            if (bus_be == 2'b01) begin
               latch_m = res_m[a-2][9:2]; lch = a - 2; lv = 1;
            end else if (bus_be[1]) begin
               flags_m[a-2] = 1'b0; lv = 0;
            end
         end
         if (bus_wr && a == 0 && bus_be != 2'b00) begin
            flags_m = '0;
            nsel = sel_m;
            if (bus_be[1]) nsel[15:8] = bus_wdata[15:8];
            if (bus_be[0]) nsel[7:0]  = bus_wdata[7:0];
            sel_m = nsel;
            if (bus_be[1]) begin
               active = (nsel != 0);
               from_m = 0;
               if (inflight) begin
                  if (cnv_done) begin inflight = 0; discard = 0; end
                  else discard = 1;
                  used = 1;
               end
            end
         end
         if (cnv_done && inflight && !used) begin
            if (discard) begin
               discard = 0; inflight = 0;
            end else begin
               res_m[mch] = cnv_data; flags_m[mch] = 1'b1;
               inflight = 0; from_m = (mch + 1) % NCH;
            end
         end
         exp_ch_q = tmp;
      end
   end

   // ---------------- converter model ----------------
   int cv_cnt = 0, cv_ch = 0, cv_n = 0;
   always @(posedge clk) begin
      cnv_done <= 1'b0;
      if (cnv_start) begin
         cv_cnt = LAT; cv_ch = int'(cnv_ch);
      end else if (cv_cnt > 0) begin
         cv_cnt--;
         if (cv_cnt == 0) begin
            cnv_done <= 1'b1;
            cnv_data <= 10'(cv_ch * 67 + cv_n * 13 + 5);
            cv_n++;
         end
      end
   end

   // ---------------- bus tasks ----------------
   logic [15:0] last_rd;
   bit          last_hit;

   task automatic do_wr(input int a, input logic [1:0] be, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 5'(a); bus_be = be; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic do_rd(input int a, input logic [1:0] be, input string tag);
      logic [15:0] e;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 5'(a); bus_be = be;
      #1;
      e = exp_rd(a, be);
      last_rd = bus_rdata;
      chk(bus_rdata == e, tag, 32'(bus_rdata), 32'(e));
      last_hit = cnv_done && (cv_ch == a - 2);
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_be = '0;
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int n0;
      bit hit;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      chk(cnv_start == 1'b0, "R1 start low after reset", 32'(cnv_start), 32'(0));
      do_rd(0, 2'b11, "R1 selection reset");
      do_rd(1, 2'b11, "R1 flags reset");
      do_rd(2, 2'b11, "R1 result0 reset");
      do_rd(17, 2'b11, "R1 result15 reset");
      cycles(5);
      chk(nstart == 0, "R1 no start before selection", 32'(nstart), 32'(0));

      // R2 / R3 sparse selection with wrap
      do_wr(0, 2'b11, 16'h8025);
      cycles(120);
      chk(nstart >= 8, "R2 sequence keeps running", 32'(nstart), 32'(8));
      do_rd(1, 2'b11, "R3 flags after sweep");
      chk(last_rd == 16'h8025, "R3 every selected channel flagged", 32'(last_rd), 32'h8025);
      do_rd(3, 2'b11, "R3 unselected result stays zero");
      do_rd(7, 2'b11, "R3 left adjusted result ch5");
      do_rd(2, 2'b11, "R8 full read ch0");
      do_rd(1, 2'b11, "R8 flag0 after full read");
      do_rd(17, 2'b11, "R8 full read ch15");
      do_rd(1, 2'b11, "R8 flag15 after full read");

      // R4 abort mid conversion
      @(negedge clk);
      while (!cnv_start) @(negedge clk);
      do_wr(0, 2'b11, 16'h0300);
      do_rd(1, 2'b11, "R4 flags cleared by write");
      chk(last_rd == 16'h0000, "R4 flags zero after restart", 32'(last_rd), 32'h0);
      cycles(80);
      do_rd(1, 2'b11, "R4 flags of new selection");
      chk(last_rd == 16'h0300, "R4 only new channels flagged", 32'(last_rd), 32'h0300);
      do_rd(10, 2'b11, "R4 result ch8");

      // R9 byte capture
      do_rd(11, 2'b01, "R9 low byte read ch9");
      do_rd(1, 2'b11, "R9 low read keeps flag");
      cycles(20);
      do_rd(11, 2'b10, "R9 high byte from capture");
      do_rd(1, 2'b11, "R9 high read clears flag");
      do_rd(11, 2'b10, "R9 high byte live after release");

      // R6 low lane write
      do_wr(0, 2'b01, 16'hAA11);
      do_rd(1, 2'b11, "R6 low write clears flags");
      do_rd(0, 2'b11, "R6 low lane only updated");
      chk(last_rd == 16'h0311, "R6 selection value", 32'(last_rd), 32'h0311);
      cycles(80);
      do_rd(1, 2'b11, "R6 sequence continues");
      chk(last_rd != 16'h0000, "R6 conversions after low write", 32'(last_rd), 32'h1);

      // R7 status byte reads
      do_rd(1, 2'b01, "R7 status low lane");
      do_rd(1, 2'b10, "R7 status high lane");
      cycles(9);
      do_rd(1, 2'b10, "R7 status high lane again live");
      do_rd(1, 2'b11, "R7 status full after byte reads");

      // R10 set wins over clear
      do_wr(0, 2'b11, 16'h0008);
      hit = 0;
      for (int k = 0; k < 300 && !hit; k++) begin
         do_rd(5, 2'b11, "R10 hammer ch3");
         hit = last_hit;
      end
      chk(hit, "R10 completion coincided with read", 32'(hit), 32'(1));
      do_rd(1, 2'b11, "R10 flag after collision");
      chk(last_rd[3] == 1'b1, "R10 set wins", 32'(last_rd[3]), 32'(1));

      // R5 stop
      do_wr(0, 2'b11, 16'h0000);
      cycles(3);
      n0 = nstart;
      cycles(60);
      chk(nstart == n0, "R5 no starts after stop", 32'(nstart), 32'(n0));
      do_rd(1, 2'b11, "R5 flags after stop");
      do_rd(0, 2'b11, "R5 selection zero");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule